// File: doc/BRIEF.md
# Full/Low Speed Tracking Controller for a Passive USB Monitor

A passive monitor on a USB segment that carries both full-speed and low-speed traffic has to know which signaling rate to decode at each moment. This block makes that choice. It watches the packet identifiers that the decoder reports, the end-of-packet strobes, a low-speed bit-time tick and a line-idle flag. From these it follows each low-speed transaction that a preamble introduces. It drives a speed select back to the receiver.

Each preamble opens a short window of low-speed decoding. What ends the window depends on the phase the transaction is in. A token phase ends after the token when the token is SETUP or OUT, and after the returned DATA packet when the token is IN. A host data phase ends after the handshake. A handshake phase after an IN ends when the handshake arrives. If the awaited packet never comes, a bit-time timeout returns decoding to full speed. On a segment that carries only low-speed traffic no preamble is ever sent, so a configuration input holds decoding at low speed permanently.

Top module: `usb_speed_tracker`

## Requirements
- R1: After reset, and while `ls_only` is low, `ls_sel` and `ls_det` are 0 (full speed) until a PID event arrives.
- R2: A PREAMBLE event (`pid_kind` = 3'd0) received at full speed sets `ls_sel` to 1 from the next clock cycle.
- R3: In the low-speed token phase, a SETUP (3'd1) or OUT (3'd2) token returns `ls_sel` to 0. The next PREAMBLE then opens a host data phase, in which a DATA event (3'd4) keeps `ls_sel` at 1.
- R4: In the host data phase, a handshake event (3'd5) that follows the DATA packet returns `ls_sel` to 0.
- R5: In the host data phase, a handshake event that arrives with no DATA packet before it returns `ls_sel` to 0.
- R6: In the low-speed token phase, an IN token (3'd3) keeps `ls_sel` at 1. The DATA event that follows returns it to 0.
- R7: After an IN sequence completes, the next PREAMBLE opens a handshake phase. In that phase a handshake event returns `ls_sel` to 0.
- R8: While low speed is selected and no PID event arrives, `ls_sel` returns to 0 on the `TIMEOUT_BITS`-th `bit_tick` (default 18) that occurs while `line_idle` is high. One tick fewer leaves it at 1.
- R9: A `bit_tick` while `line_idle` is low is not counted toward the timeout, and an `eop` strobe restarts the count from zero.
- R10: Any PID event that the current low-speed phase does not expect returns `ls_sel` to 0 and clears the pending phase. The next PREAMBLE therefore opens a token phase, in which an IN token keeps low speed.
- R11: While `ls_only` is 1, `ls_sel` is 1 regardless of PID events, ticks or timeouts.
- R12: `ls_det` equals `ls_sel` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pid_valid | input | 1 | One-cycle strobe: a decoded PID is reported on `pid_kind` |
| pid_kind | input | 3 | PID class: 0 preamble, 1 SETUP, 2 OUT, 3 IN, 4 DATA, 5 handshake, 6-7 other |
| eop | input | 1 | End-of-packet strobe |
| bit_tick | input | 1 | One-cycle strobe per low-speed bit time |
| line_idle | input | 1 | Line is in the idle state |
| ls_only | input | 1 | Segment carries low-speed traffic only |
| ls_sel | output | 1 | 1 selects low-speed decoding |
| ls_det | output | 1 | Low-speed detect indication |

## Verification
The hardest states to reach are the two phases that exist only because of an earlier transaction: the host data phase, which follows a SETUP or OUT, and the handshake phase, which follows a completed IN. Both look the same at the ports as an ordinary token phase. The bench reaches them by playing complete preamble, token and return sequences. It then tells the phases apart by how a later PID is treated: after a fresh preamble, an IN keeps low speed only in a token phase. Timeout edges are probed one tick short of the limit and exactly at it, with ticks while the line is busy and an end-of-packet strobe in between.

// File: rtl/usb_speed_tracker.sv
module usb_speed_tracker #(
  parameter int TIMEOUT_BITS = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pid_valid,
  input  logic [2:0] pid_kind,
  input  logic       eop,
  input  logic       bit_tick,
  input  logic       line_idle,
  input  logic       ls_only,
  output logic       ls_sel,
  output logic       ls_det
);
  localparam int CW = $clog2(TIMEOUT_BITS + 1);
  localparam logic [2:0] K_PRE = 3'd0, K_SETUP = 3'd1, K_OUT = 3'd2,
                         K_IN = 3'd3, K_DATA = 3'd4, K_HS = 3'd5;

  typedef enum logic [2:0] {
    ST_FULL, ST_TOKEN, ST_IN_DATA, ST_HOST_DATA, ST_HOST_HS, ST_IN_HS
  } state_t;
  typedef enum logic [1:0] {PEND_NONE, PEND_OUT, PEND_IN} pend_t;

  state_t        state, state_nx;
  pend_t         pend, pend_nx;
  logic [CW-1:0] cnt;
  logic          in_ls, expire;

  assign in_ls  = (state != ST_FULL);
  assign expire = in_ls && bit_tick && line_idle && (cnt == CW'(TIMEOUT_BITS - 1));
  assign ls_sel = ls_only | in_ls;
  assign ls_det = ls_sel;

  always_comb begin
    state_nx = state;
    pend_nx  = pend;
    if (pid_valid) begin
      state_nx = ST_FULL;
      case (state)
        ST_FULL: begin
          if (pid_kind == K_PRE) begin
            pend_nx = PEND_NONE;
            case (pend)
              PEND_OUT: state_nx = ST_HOST_DATA;
              PEND_IN:  state_nx = ST_IN_HS;
              default:  state_nx = ST_TOKEN;
            endcase
          end else if (pid_kind == K_SETUP || pid_kind == K_OUT || pid_kind == K_IN) begin
            pend_nx = PEND_NONE;
          end
        end
        ST_TOKEN: begin
          pend_nx = PEND_NONE;
          if (pid_kind == K_SETUP || pid_kind == K_OUT) pend_nx = PEND_OUT;
          else if (pid_kind == K_IN) state_nx = ST_IN_DATA;
        end
        ST_IN_DATA: pend_nx = (pid_kind == K_DATA) ? PEND_IN : PEND_NONE;
        ST_HOST_DATA: begin
          pend_nx = PEND_NONE;
          if (pid_kind == K_DATA) state_nx = ST_HOST_HS;
        end
        default: pend_nx = PEND_NONE;
      endcase
    end else if (expire) begin
      state_nx = ST_FULL;
      pend_nx  = PEND_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ls_only) begin
      state <= ST_FULL;
      pend  <= PEND_NONE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      pend  <= pend_nx;
      if (!in_ls || pid_valid || eop || expire) cnt <= '0;
      else if (bit_tick && line_idle)          cnt <= cnt + 1'b1;
    end
  end

  a_r2_pre_enters_ls: assert property (@(posedge clk) disable iff (!rst_n)
    (!ls_only && state == ST_FULL && pid_valid && pid_kind == K_PRE) |=> ls_sel);
  a_r3_token_out_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (!ls_only && state == ST_TOKEN && pid_valid && (pid_kind == K_SETUP || pid_kind == K_OUT))
    |=> (!ls_sel && pend == PEND_OUT));
  a_r8_timeout_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!ls_only && expire && !pid_valid) |=> !ls_sel);
  a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(TIMEOUT_BITS));
  a_r9_busy_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!ls_only && in_ls && !pid_valid && !eop && !line_idle) |=> (cnt == $past(cnt)));
  a_r11_only_forces: assert property (@(posedge clk) disable iff (!rst_n)
    ls_only |-> ls_sel);
endmodule

// File: tb/usb_speed_tracker_tb.sv
module usb_speed_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TOB = 18;
  localparam logic [2:0] PRE = 3'd0, SETUP = 3'd1, OUTT = 3'd2, INT = 3'd3,
                         DATA = 3'd4, HS = 3'd5, OTHER = 3'd7;

  logic clk = 0, rst_n = 0, pid_valid = 0, eop = 0, bit_tick = 0, line_idle = 1, ls_only = 0;
  logic [2:0] pid_kind = 3'd0;
  logic ls_sel, ls_det;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_speed_tracker #(.TIMEOUT_BITS(TOB)) u_dut (
    .clk(clk), .rst_n(rst_n), .pid_valid(pid_valid), .pid_kind(pid_kind),
    .eop(eop), .bit_tick(bit_tick), .line_idle(line_idle), .ls_only(ls_only),
    .ls_sel(ls_sel), .ls_det(ls_det));

  task automatic chk(input logic exp, input string req);
    checks++;
    if (ls_sel !== exp) begin
      failures++;
      $display("FAIL %s ls_sel=%b expected=%b", req, ls_sel, exp);
    end
    checks++;
    if (ls_det !== ls_sel) begin
      failures++;
      $display("FAIL R12 (%s) ls_det=%b expected=%b", req, ls_det, ls_sel);
    end
  endtask

  task automatic pid(input logic [2:0] k);
    @(negedge clk); pid_valid = 1; pid_kind = k;
    @(negedge clk); pid_valid = 0; pid_kind = 3'd0;
  endtask

  task automatic ticks(input int n, input logic idle);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1; line_idle = idle;
      @(negedge clk); bit_tick = 0; line_idle = 1;
    end
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset;
    do_reset();
    chk(1'b0, "R1");
  endtask

  task automatic t_out_seq;
    do_reset();
    pid(PRE);   chk(1'b1, "R2");
    pid(SETUP); chk(1'b0, "R3");
    pid(PRE);   chk(1'b1, "R3");
    pid(DATA);  chk(1'b1, "R3");
    pid(HS);    chk(1'b0, "R4");
  endtask

  task automatic t_out_no_data;
    do_reset();
    pid(PRE); pid(OUTT); chk(1'b0, "R3");
    pid(PRE); chk(1'b1, "R5");
    pid(HS);  chk(1'b0, "R5");
  endtask

  task automatic t_in_seq;
    do_reset();
    pid(PRE);  pid(INT); chk(1'b1, "R6");
    pid(DATA); chk(1'b0, "R6");
    pid(PRE);  chk(1'b1, "R7");
    pid(HS);   chk(1'b0, "R7");
  endtask

  task automatic t_timeout;
    do_reset();
    pid(PRE);
    ticks(TOB - 1, 1'b1); chk(1'b1, "R8");
    ticks(1, 1'b1);       chk(1'b0, "R8");
  endtask

  task automatic t_busy_and_eop;
    do_reset();
    pid(PRE);
    ticks(10, 1'b1);
    @(negedge clk); eop = 1; @(negedge clk); eop = 0;
    ticks(TOB - 1, 1'b1); chk(1'b1, "R9");
    ticks(5, 1'b0);       chk(1'b1, "R9");
    ticks(1, 1'b1);       chk(1'b0, "R9");
  endtask

  task automatic t_unexpected;
    do_reset();
    pid(PRE); pid(SETUP); pid(PRE);
    pid(OTHER); chk(1'b0, "R10");
    pid(PRE);   pid(INT); chk(1'b1, "R10");
  endtask

  task automatic t_ls_only;
    do_reset();
    @(negedge clk); ls_only = 1;
    @(negedge clk); chk(1'b1, "R11");
    pid(PRE); pid(SETUP); chk(1'b1, "R11");
    ticks(TOB + 2, 1'b1); chk(1'b1, "R11");
    @(negedge clk); ls_only = 0;
    @(negedge clk); chk(1'b0, "R11");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_out_seq();
    t_out_no_data();
    t_in_seq();
    t_timeout();
    t_busy_and_eop();
    t_unexpected();
    t_ls_only();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule